// File: doc/BRIEF.md
# Single-Accumulator Processor Core

This block is a small processor built around one 8-bit accumulator and an 8-bit program counter. It fetches 16-bit instructions from an external instruction memory, decodes them and executes them one at a time. An instruction word splits into three fields. The top nibble selects the operation. The next nibble selects an ALU function. The low byte is either an immediate operand or a data-memory address.

The core supports five operations: add or subtract an immediate, add or subtract a data-memory word, clear the accumulator, store the accumulator to memory, and branch when the accumulator is zero. Both memories are synchronous: an address presented in one cycle returns its data in the next. A small phase machine therefore spends a fixed number of cycles on each instruction: fetch, decode, an optional memory-read wait, and execute. The accumulator and program counter are brought out as ports for observation.

Top module: `acc_core`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets the program counter and the accumulator to 0, and the next instruction fetch is taken from address 0.
- R2: An instruction word carries its operation code in bits [15:12], its ALU function in bits [11:8] and its operand (immediate or address) in bits [7:0].
- R3: Operation 0x1 replaces the accumulator with accumulator plus operand when the ALU function is 0x0, and with accumulator minus operand when it is 0x1, both modulo 256.
- R4: Operation 0x2 does the same as R3, but the second operand is the data-memory byte at the address in bits [7:0].
- R5: Operation 0x3 sets the accumulator to 0 whatever the other twelve bits hold.
- R6: Operation 0x4 writes the accumulator to the data memory at the address in bits [7:0] with a single one-cycle write strobe, whatever the ALU function field holds.
- R7: Operation 0x5 loads the program counter with bits [7:0] when the accumulator is 0, and otherwise advances the program counter by one.
- R8: Except for a taken branch, every instruction advances the program counter by one, and 255 is followed by 0.
- R9: Operation codes 0x0 and 0x6 to 0xF, and ALU functions other than 0x0 and 0x1 under operations 0x1 and 0x2, leave the accumulator unchanged and write nothing to memory.
- R10: An operation-0x2 instruction takes 4 clock cycles and every other instruction takes 3. The program counter and accumulator change only at the last edge of an instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 8 | Instruction memory read address |
| imem_rdata | input | 16 | Instruction word, valid one cycle after the address |
| dmem_addr | output | 8 | Data memory address for read and write |
| dmem_rdata | input | 8 | Data memory read byte, valid one cycle after the address |
| dmem_wdata | output | 8 | Byte to write (the accumulator) |
| dmem_we | output | 1 | Data memory write strobe |
| acc_o | output | 8 | Current accumulator value |
| pc_o | output | 8 | Current program counter value |

## Verification
One program exercises every operation in sequence. It includes an immediate subtract that wraps below zero, an immediate add that wraps above 255, and a memory-operand add and subtract. These separate the two ALU functions and separate the immediate path from the memory path. A store is followed by a clear and then by a memory-operand add from the same address, so a missing or misplaced write becomes visible in the accumulator. The program also includes a branch on a non-zero accumulator and branches on a zero accumulator, one of them to address 255 so that the program counter wraps. Undefined operation codes, unsupported ALU functions and a reset in the middle of an instruction complete the set. Each step is checked one cycle before its last edge as well as after it, which pins down the cycle count per instruction.

// File: rtl/acc_pkg.sv
package acc_pkg;

    localparam int OPC_W   = 4;
    localparam int OPT_W   = 4;
    localparam int ARG_W   = 8;
    localparam int DATA_W  = 8;
    localparam int INSTR_W = OPC_W + OPT_W + ARG_W;

    typedef logic [OPC_W-1:0] opc_t;
    typedef logic [OPT_W-1:0] opt_t;

    localparam opc_t OPC_ALU_IMM = 4'h1;
    localparam opc_t OPC_ALU_MEM = 4'h2;
    localparam opc_t OPC_CLEAR   = 4'h3;
    localparam opc_t OPC_STORE   = 4'h4;
    localparam opc_t OPC_BRZ     = 4'h5;

    localparam opt_t FN_ADD = 4'h0;
    localparam opt_t FN_SUB = 4'h1;

    typedef enum logic [1:0] {
        PH_FETCH  = 2'd0,
        PH_DECODE = 2'd1,
        PH_MEMRD  = 2'd2,
        PH_EXEC   = 2'd3
    } phase_e;

    typedef struct packed {
        opc_t             opc;
        opt_t             fn;
        logic [ARG_W-1:0] arg;
    } instr_t;

    typedef struct packed {
        logic acc_load;
        logic acc_clear;
        logic mem_write;
        logic pc_jump;
        logic mem_operand;
    } ctrl_t;

endpackage

// File: rtl/acc_alu.sv
module acc_alu
    import acc_pkg::*;
(
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    input  opt_t              fn,
    output logic [DATA_W-1:0] result,
    output logic              supported
);

    always_comb begin
        result    = lhs;
        supported = 1'b0;
        case (fn)
            FN_ADD: begin
                result    = lhs + rhs;
                supported = 1'b1;
            end
            FN_SUB: begin
                result    = lhs - rhs;
                supported = 1'b1;
            end
            default: begin
                result    = lhs;
                supported = 1'b0;
            end
        endcase
    end

    // R9
    unsupported_keeps_lhs_chk: assert final (supported || result == lhs);

endmodule

// File: rtl/acc_decode.sv
module acc_decode
    import acc_pkg::*;
(
    input  opc_t  opc,
    input  logic  acc_zero,
    output ctrl_t ctl
);

    always_comb begin
        ctl = '0;
        case (opc)
            OPC_ALU_IMM: ctl.acc_load = 1'b1;
            OPC_ALU_MEM: begin
                ctl.acc_load    = 1'b1;
                ctl.mem_operand = 1'b1;
            end
            OPC_CLEAR:   ctl.acc_clear = 1'b1;
            OPC_STORE:   ctl.mem_write = 1'b1;
            OPC_BRZ:     ctl.pc_jump   = acc_zero;
            default:     ctl = '0;
        endcase
    end

    // R9
    one_action_chk: assert final ($countones({ctl.acc_load, ctl.acc_clear, ctl.mem_write, ctl.pc_jump}) <= 1);

endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    output logic [ARG_W-1:0]   imem_addr,
    input  logic [INSTR_W-1:0] imem_rdata,
    output logic [ARG_W-1:0]   dmem_addr,
    input  logic [DATA_W-1:0]  dmem_rdata,
    output logic [DATA_W-1:0]  dmem_wdata,
    output logic               dmem_we,
    output logic [DATA_W-1:0]  acc_o,
    output logic [ARG_W-1:0]   pc_o
);

    typedef struct packed {
        phase_e            phase;
        logic [ARG_W-1:0]  pc;
        logic [DATA_W-1:0] acc;
        instr_t            ir;
    } core_t;

    localparam core_t CORE_RESET = '{phase: PH_FETCH, pc: '0, acc: '0, ir: '0};

    core_t core_d, core_q;
    ctrl_t ctl;
    instr_t            fetched;
    logic [DATA_W-1:0] alu_rhs;
    logic [DATA_W-1:0] alu_res;
    logic              alu_ok;

    assign fetched = instr_t'(imem_rdata);

    acc_decode u_decode (
        .opc      (core_q.ir.opc),
        .acc_zero (core_q.acc == '0),
        .ctl      (ctl)
    );

    assign alu_rhs = ctl.mem_operand ? dmem_rdata : core_q.ir.arg;

    acc_alu u_alu (
        .lhs       (core_q.acc),
        .rhs       (alu_rhs),
        .fn        (core_q.ir.fn),
        .result    (alu_res),
        .supported (alu_ok)
    );

    always_comb begin
        core_d = core_q;
        case (core_q.phase)
            PH_FETCH: core_d.phase = PH_DECODE;
            PH_DECODE: begin
                core_d.ir    = fetched;
                core_d.phase = (fetched.opc == OPC_ALU_MEM) ? PH_MEMRD : PH_EXEC;
            end
            PH_MEMRD: core_d.phase = PH_EXEC;
            PH_EXEC: begin
                if (ctl.acc_clear) begin
                    core_d.acc = '0;
                end else if (ctl.acc_load && alu_ok) begin
                    core_d.acc = alu_res;
                end
                core_d.pc    = ctl.pc_jump ? core_q.ir.arg : core_q.pc + ARG_W'(1);
                core_d.phase = PH_FETCH;
            end
            default: core_d.phase = PH_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            core_q <= CORE_RESET;
        end else begin
            core_q <= core_d;
        end
    end

    assign imem_addr  = core_q.pc;
    assign dmem_addr  = core_q.ir.arg;
    assign dmem_wdata = core_q.acc;
    assign dmem_we    = (core_q.phase == PH_EXEC) && ctl.mem_write;
    assign acc_o      = core_q.acc;
    assign pc_o       = core_q.pc;

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (core_q.pc == '0 && core_q.acc == '0 && core_q.phase == PH_FETCH));

    // R10
    pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (core_q.phase != PH_EXEC) |=> ($stable(core_q.pc) && $stable(core_q.acc)));

    // R8
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (core_q.phase == PH_EXEC && core_q.ir.opc != OPC_BRZ) |=> core_q.pc == ARG_W'($past(core_q.pc) + ARG_W'(1)));

    // R7
    branch_take_chk: assert property (@(posedge clk) disable iff (rst)
        (core_q.phase == PH_EXEC && core_q.ir.opc == OPC_BRZ && core_q.acc == '0) |=> core_q.pc == $past(core_q.ir.arg));

    // R5
    clear_acc_chk: assert property (@(posedge clk) disable iff (rst)
        (core_q.phase == PH_EXEC && core_q.ir.opc == OPC_CLEAR) |=> core_q.acc == '0);

    // R9
    undef_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (core_q.phase == PH_EXEC && (core_q.ir.opc == 4'h0 || core_q.ir.opc > OPC_BRZ)) |=> ($stable(core_q.acc) && !$past(dmem_we)));

    // R6
    store_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        dmem_we |=> !dmem_we);

endmodule

// File: tb/tb_acc_core.sv
`timescale 1ns/1ps
module tb_acc_core;
    import acc_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  imem_addr;
    logic [15:0] imem_rdata;
    logic [7:0]  dmem_addr;
    logic [7:0]  dmem_rdata;
    logic [7:0]  dmem_wdata;
    logic        dmem_we;
    logic [7:0]  acc_o;
    logic [7:0]  pc_o;

    always #4 clk = ~clk;

    acc_core dut (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_rdata (dmem_rdata),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .acc_o      (acc_o),
        .pc_o       (pc_o)
    );

    logic [15:0] imem [256];
    logic [7:0]  dmem [256];
    int          wr_count = 0;
    logic [7:0]  wr_addr  = '0;
    logic [7:0]  wr_data  = '0;

    always @(posedge clk) begin
        imem_rdata <= imem[imem_addr];
        dmem_rdata <= dmem[dmem_addr];
        if (dmem_we) begin
            dmem[dmem_addr] <= dmem_wdata;
            if (!rst) begin
                wr_count <= wr_count + 1;
                wr_addr  <= dmem_addr;
                wr_data  <= dmem_wdata;
            end
        end
    end

    // {location, instruction, expected acc, expected pc, cycles}
    localparam int NSTEP = 21;
    localparam logic [43:0] PROG [NSTEP] = '{
        {8'h00, 16'h1005, 8'h05, 8'h01, 4'd3},
        {8'h01, 16'h1103, 8'h02, 8'h02, 4'd3},
        {8'h02, 16'h1110, 8'hF2, 8'h03, 4'd3},
        {8'h03, 16'h1020, 8'h12, 8'h04, 4'd3},
        {8'h04, 16'h200A, 8'h5D, 8'h05, 4'd4},
        {8'h05, 16'h2103, 8'h43, 8'h06, 4'd4},
        {8'h06, 16'h1244, 8'h43, 8'h07, 4'd3},
        {8'h07, 16'h7ABC, 8'h43, 8'h08, 4'd3},
        {8'h08, 16'h4F20, 8'h43, 8'h09, 4'd3},
        {8'h09, 16'h3FFF, 8'h00, 8'h0A, 4'd3},
        {8'h0A, 16'h2020, 8'h43, 8'h0B, 4'd4},
        {8'h0B, 16'h5030, 8'h43, 8'h0C, 4'd3},
        {8'h0C, 16'h1143, 8'h00, 8'h0D, 4'd3},
        {8'h0D, 16'h5030, 8'h00, 8'h30, 4'd3},
        {8'h30, 16'h0FFF, 8'h00, 8'h31, 4'd3},
        {8'h31, 16'h2AFF, 8'h00, 8'h32, 4'd4},
        {8'h32, 16'h21FF, 8'h02, 8'h33, 4'd4},
        {8'h33, 16'h50FE, 8'h02, 8'h34, 4'd3},
        {8'h34, 16'h3000, 8'h00, 8'h35, 4'd3},
        {8'h35, 16'h50FF, 8'h00, 8'hFF, 4'd3},
        {8'hFF, 16'h1001, 8'h01, 8'h00, 4'd3}
    };

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Fields decoded per R2: operation in [15:12], ALU function in [11:8].
    function automatic string acc_req(input logic [15:0] ins);
        case (ins[15:12])
            4'h1:    return (ins[11:8] > 4'h1) ? "R9 unsupported fn" : "R3 immediate ALU (R2)";
            4'h2:    return (ins[11:8] > 4'h1) ? "R9 unsupported fn" : "R4 memory ALU (R2)";
            4'h3:    return "R5 clear";
            4'h4:    return "R6 store";
            4'h5:    return "R7 branch acc";
            default: return "R9 undefined opcode";
        endcase
    endfunction

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            imem[i] = 16'h0000;
            dmem[i] = 8'(i * 7 + 5);
        end
        for (int i = 0; i < NSTEP; i++) begin
            imem[PROG[i][43:36]] = PROG[i][35:20];
        end

        // R1: state held in reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(pc_o == 8'h00, "R1 reset pc", 16'(pc_o), 16'h0);
        chk(acc_o == 8'h00, "R1 reset acc", 16'(acc_o), 16'h0);
        chk(dmem_we == 1'b0, "R1 reset no write", 16'(dmem_we), 16'h0);
        rst = 1'b0;

        for (int i = 0; i < NSTEP; i++) begin
            logic [7:0]  loc;
            logic [15:0] ins;
            logic [7:0]  eacc;
            logic [7:0]  epc;
            logic [3:0]  cyc;
            logic [7:0]  prev_acc;
            {loc, ins, eacc, epc, cyc} = PROG[i];
            prev_acc = acc_o;
            chk(pc_o == loc, "R8 start pc", 16'(pc_o), 16'(loc));
            repeat (int'(cyc) - 1) @(posedge clk);
            @(negedge clk);
            // R10: nothing visible changes before the last edge
            chk(pc_o == loc && acc_o == prev_acc, "R10 hold before commit",
                {acc_o, pc_o}, {prev_acc, loc});
            @(posedge clk);
            @(negedge clk);
            chk(acc_o == eacc, acc_req(ins), 16'(acc_o), 16'(eacc));
            chk(pc_o == epc, (ins[15:12] == 4'h5) ? "R7 branch pc" : "R8 pc step",
                16'(pc_o), 16'(epc));
        end

        // R6 / R9: exactly one write, from the store, none from no-ops
        chk(wr_count == 1, "R9 write count", 16'(wr_count), 16'd1);
        chk(wr_addr == 8'h20 && wr_data == 8'h43, "R6 store target",
            {wr_addr, wr_data}, 16'h2043);

        // R1: reset in the middle of an instruction (acc is 1 here)
        @(posedge clk);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(pc_o == 8'h00, "R1 mid reset pc", 16'(pc_o), 16'h0);
        chk(acc_o == 8'h00, "R1 mid reset acc", 16'(acc_o), 16'h0);
        rst = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(acc_o == 8'h05 && pc_o == 8'h01, "R1 restart from 0",
            {acc_o, pc_o}, 16'h0501);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule